// File: doc/BRIEF.md
# Parallel-bus ADC conversion sequencer

This block sits on the host side of a self-timed parallel analog-to-digital converter. It takes a conversion request made of a 2-bit channel number and drives the converter's active-low strobes: chip select, sample/hold and read. It then waits for the converter's active-low end-of-conversion line and captures the 10-bit data bus. The captured word and the channel it came from are offered to a consumer on a valid/ready port. Every converter timing limit is given in nanoseconds and turned into a whole number of system clock cycles, rounded up.

Two strobe schemes are supported, chosen by the `conv_mode` input when a request is accepted. With `conv_mode` = 0 (split strobes), a timed sample pulse starts the conversion and a separate read pulse fetches the result once the converter signals completion. With `conv_mode` = 1 (joint strobe), sample/hold and read fall together and stay low until completion. While they are low the bus still carries the previous result, so the block captures only after completion has been seen. The end-of-conversion line passes through a two-stage synchroniser.

The sequencer is built around one state machine. Its states are IDLE, SETUP, SAMPLE, CONV, READ, SETTLE and GAP, and its transitions are these:
- IDLE goes to SETUP when a request is accepted.
- SETUP goes to SAMPLE once the select setup count has run out.
- SAMPLE goes to CONV in split mode, after the minimum sample width.
- SAMPLE goes to SETTLE in joint mode, when completion is seen.
- CONV goes to READ when completion is seen.
- READ goes to GAP after the access window, capturing the bus.
- SETTLE goes to GAP after the short data delay, capturing the bus.
- SAMPLE or CONV goes to GAP on a timeout.
- GAP goes to IDLE after the turnaround count.

Top module: `adcseq_ctrl`

## Requirements
- R1: `adc_cs_n` is low exactly from the cycle after a request is accepted until the cycle after capture or timeout. `adc_sh_n` and `adc_rd_n` are never low while `adc_cs_n` is high.
- R2: `adc_sel` carries the accepted channel from the cycle after acceptance and stays unchanged while chip select is low. The encoding is 00 for channel 0, 01 for channel 1, 10 for channel 2 and 11 for channel 3. `res_chan` returns the channel that was on `adc_sel` when sample/hold fell.
- R3: `adc_sh_n` falls exactly ceil(75 ns / period) cycles after chip select falls. At 20 ns this is 4 cycles.
- R4: In split mode, `adc_sh_n` stays low for ceil(250 ns / period) cycles (13 at 20 ns) with `adc_rd_n` high. It then stays high until the synchronised end-of-conversion line is seen low.
- R5: In split mode, `adc_rd_n` is low for ceil(60 ns / period)+1 cycles (4 at 20 ns), starting the cycle after completion is seen. The bus is captured at the edge that ends this window.
- R6: In joint mode, `adc_sh_n` and `adc_rd_n` fall in the same cycle. They stay low until completion is seen, plus ceil(20 ns / period) cycles (1 at 20 ns). The captured word is the new conversion and never the previous result shown on the bus before completion.
- R7: After capture or timeout, all strobes stay high for at least ceil(50 ns / period) cycles (3 at 20 ns) before the next chip select falls.
- R8: If completion is not seen within `TIMEOUT_CYC` cycles of waiting (100 by default), the strobes are released and `timeout_err` pulses high for exactly one cycle. No result is produced.
- R9: `start_ready` is high only in IDLE with no result pending. A request is taken only on `start_valid` and `start_ready` both high, and chip select stays high otherwise.
- R10: `res_valid` rises the cycle after capture. `res_data` and `res_chan` hold steady while `res_valid` is high and `res_ready` is low. A cycle with both high clears `res_valid`.
- R11: During and right after reset, all strobes are high, `res_valid` and `timeout_err` are low, and `start_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_mode | input | 1 | 0 selects split strobes, 1 selects a joint sample/read strobe; taken at acceptance |
| start_valid | input | 1 | Conversion request |
| start_chan | input | 2 | Channel requested |
| start_ready | output | 1 | Request can be accepted |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sh_n | output | 1 | Converter sample/hold strobe, active low |
| adc_rd_n | output | 1 | Converter read strobe, active low |
| adc_sel | output | 2 | Converter channel select lines |
| adc_int_n | input | 1 | Converter end-of-conversion, active low, asynchronous |
| adc_data | input | 10 | Converter data bus |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 10 | Converted value |
| res_chan | output | 2 | Channel of the converted value |
| timeout_err | output | 1 | One-cycle pulse when a conversion timed out |

## Verification
Counting from the edge that accepts a request:
- Chip select and the select lines change one cycle later.
- Sample/hold falls 4 cycles after that.
- In split mode it rises again 13 cycles later.
- Completion reaches the state machine two edges after the bench drives the end-of-conversion line low.
- From there, the read window takes 4 cycles in split mode, or the joint strobe holds 1 more cycle.
- `res_valid` appears one cycle after capture.
- A timeout pulse appears one cycle after the 100th waiting cycle.

The bench has a behavioural reference model that advances on each rising edge with the same two-edge synchroniser delay. Every output is compared with the model on every falling edge, so each result is checked in the exact cycle it is due. Event monitors separately measure the setup, sample-width, joint-strobe and turnaround cycle counts. Each returned word is compared with the analog value the bench presented for that channel at the sample edge.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SAMPLE,
        ST_CONV,
        ST_READ,
        ST_SETTLE,
        ST_GAP
    } seq_state_t;

    typedef enum logic {
        MODE_SPLIT = 1'b0,
        MODE_JOINT = 1'b1
    } conv_mode_t;

    // Nanoseconds to whole cycles, rounded up, never below one.
    function automatic int ns_to_cyc(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adcseq_sync.sv
module adcseq_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int N = (STAGES < 2) ? 2 : STAGES;

    logic [N-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {N{RESET_VAL}};
        end else begin
            chain <= {chain[N-2:0], d};
        end
    end

    assign q = chain[N-1];
endmodule

// File: rtl/adcseq_timer.sv
module adcseq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (count != {W{1'b1}}) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/adcseq_result.sv
module adcseq_result #(
    parameter int DATA_W = 10,
    parameter int CHAN_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic [CHAN_W-1:0] load_chan,
    output logic              valid,
    input  logic              ready,
    output logic [DATA_W-1:0] data,
    output logic [CHAN_W-1:0] chan
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
            chan  <= '0;
        end else if (load) begin
            valid <= 1'b1;
            data  <= load_data;
            chan  <= load_chan;
        end else if (valid && ready) begin
            valid <= 1'b0;
        end
    end

    // R10
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(data) && $stable(chan)));

    // R10
    res_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready && !load) |=> !valid);
endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
    import adcseq_pkg::*;
#(
    parameter int CLK_NS       = 20,
    parameter int DATA_W       = 10,
    parameter int CHAN_W       = 2,
    parameter int SYNC_STAGES  = 2,
    parameter int TIMEOUT_CYC  = 100,
    parameter int T_SETUP_NS   = 75,
    parameter int T_SAMPLE_NS  = 250,
    parameter int T_ACCESS_NS  = 60,
    parameter int T_SETTLE_NS  = 20,
    parameter int T_GAP_NS     = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_mode,
    input  logic              start_valid,
    input  logic [CHAN_W-1:0] start_chan,
    output logic              start_ready,
    output logic              adc_cs_n,
    output logic              adc_sh_n,
    output logic              adc_rd_n,
    output logic [CHAN_W-1:0] adc_sel,
    input  logic              adc_int_n,
    input  logic [DATA_W-1:0] adc_data,
    output logic              res_valid,
    input  logic              res_ready,
    output logic [DATA_W-1:0] res_data,
    output logic [CHAN_W-1:0] res_chan,
    output logic              timeout_err
);
    localparam int SETUP_CYC  = ns_to_cyc(T_SETUP_NS, CLK_NS);
    localparam int SAMPLE_CYC = ns_to_cyc(T_SAMPLE_NS, CLK_NS);
    // one extra cycle so capture lands strictly after the access limit
    localparam int READ_CYC   = ns_to_cyc(T_ACCESS_NS, CLK_NS) + 1;
    localparam int SETTLE_CYC = ns_to_cyc(T_SETTLE_NS, CLK_NS);
    localparam int GAP_CYC    = ns_to_cyc(T_GAP_NS, CLK_NS);
    localparam int WAIT_CYC   = (TIMEOUT_CYC < 1) ? 1 : TIMEOUT_CYC;
    localparam int CNT_TOP    = max_of(max_of(max_of(SETUP_CYC, SAMPLE_CYC),
                                              max_of(READ_CYC, SETTLE_CYC)),
                                       max_of(GAP_CYC, WAIT_CYC));
    localparam int CNT_W      = $clog2(CNT_TOP + 1);

    localparam logic [CNT_W-1:0] SETUP_LAST  = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] SAMPLE_LAST = CNT_W'(SAMPLE_CYC - 1);
    localparam logic [CNT_W-1:0] READ_LAST   = CNT_W'(READ_CYC - 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_LAST    = CNT_W'(GAP_CYC - 1);
    localparam logic [CNT_W-1:0] WAIT_LAST   = CNT_W'(WAIT_CYC - 1);

    seq_state_t        state_q, state_d;
    conv_mode_t        mode_q;
    logic [CHAN_W-1:0] chan_q;
    logic [CNT_W-1:0]  cnt;
    logic              cnt_clr;
    logic              int_s;
    logic              capture;
    logic              to_hit;
    logic              err_q;
    logic              accept;

    // end-of-conversion comes from another timing domain
    adcseq_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) i_int_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (adc_int_n),
        .q     (int_s)
    );

    adcseq_timer #(
        .W (CNT_W)
    ) i_phase_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .count (cnt)
    );

    adcseq_result #(
        .DATA_W (DATA_W),
        .CHAN_W (CHAN_W)
    ) i_result (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (capture),
        .load_data (adc_data),
        .load_chan (chan_q),
        .valid     (res_valid),
        .ready     (res_ready),
        .data      (res_data),
        .chan      (res_chan)
    );

    assign start_ready = (state_q == ST_IDLE) && !res_valid;
    assign accept      = start_valid && start_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        to_hit  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = ST_SETUP;
            end
            ST_SETUP: begin
                if (cnt == SETUP_LAST) state_d = ST_SAMPLE;
            end
            ST_SAMPLE: begin
                if (mode_q == MODE_SPLIT) begin
                    if (cnt == SAMPLE_LAST) state_d = ST_CONV;
                end else if (!int_s) begin
                    state_d = ST_SETTLE;
                end else if (cnt == WAIT_LAST) begin
                    state_d = ST_GAP;
                    to_hit  = 1'b1;
                end
            end
            ST_CONV: begin
                if (!int_s) begin
                    state_d = ST_READ;
                end else if (cnt == WAIT_LAST) begin
                    state_d = ST_GAP;
                    to_hit  = 1'b1;
                end
            end
            ST_READ: begin
                if (cnt == READ_LAST) begin
                    state_d = ST_GAP;
                    capture = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (cnt == SETTLE_LAST) begin
                    state_d = ST_GAP;
                    capture = 1'b1;
                end
            end
            ST_GAP: begin
                if (cnt == GAP_LAST) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign cnt_clr = (state_d != state_q);

    // request latch: channel and mode are frozen for the whole transaction
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q <= '0;
            mode_q <= MODE_SPLIT;
        end else if (accept) begin
            chan_q <= start_chan;
            mode_q <= conv_mode_t'(conv_mode);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= to_hit;
        end
    end

    // outputs
    always_comb begin
        adc_cs_n = 1'b1;
        adc_sh_n = 1'b1;
        adc_rd_n = 1'b1;
        unique case (state_q)
            ST_IDLE, ST_GAP: ;
            ST_SETUP, ST_CONV: adc_cs_n = 1'b0;
            ST_SAMPLE: begin
                adc_cs_n = 1'b0;
                adc_sh_n = 1'b0;
                adc_rd_n = (mode_q == MODE_JOINT) ? 1'b0 : 1'b1;
            end
            ST_READ: begin
                adc_cs_n = 1'b0;
                adc_rd_n = 1'b0;
            end
            ST_SETTLE: begin
                adc_cs_n = 1'b0;
                adc_sh_n = 1'b0;
                adc_rd_n = 1'b0;
            end
            default: ;
        endcase
    end

    assign adc_sel     = chan_q;
    assign timeout_err = err_q;

    // checker counters for strobe timing
    logic [CNT_W-1:0] cs_low_cnt, cs_high_cnt, sh_low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_low_cnt  <= '0;
            cs_high_cnt <= {CNT_W{1'b1}};
            sh_low_cnt  <= '0;
        end else begin
            cs_low_cnt  <= adc_cs_n ? '0 :
                           ((cs_low_cnt == {CNT_W{1'b1}}) ? cs_low_cnt : cs_low_cnt + 1'b1);
            cs_high_cnt <= !adc_cs_n ? '0 :
                           ((cs_high_cnt == {CNT_W{1'b1}}) ? cs_high_cnt : cs_high_cnt + 1'b1);
            sh_low_cnt  <= adc_sh_n ? '0 :
                           ((sh_low_cnt == {CNT_W{1'b1}}) ? sh_low_cnt : sh_low_cnt + 1'b1);
        end
    end

    // R1
    strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_sh_n || !adc_rd_n) |-> !adc_cs_n);

    // R2
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_cs_n) |=> (adc_cs_n || $stable(adc_sel)));

    // R3
    sel_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_sh_n) |-> (cs_low_cnt >= CNT_W'(SETUP_CYC)));

    // R4
    sample_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(adc_sh_n) && !adc_cs_n) |-> (sh_low_cnt >= CNT_W'(SAMPLE_CYC)));

    // R6
    joint_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(adc_sh_n) && (mode_q == MODE_JOINT)) |-> $fell(adc_rd_n));

    // R7
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n) |-> (cs_high_cnt >= CNT_W'(GAP_CYC)));

    // R8
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |=> !timeout_err);

    // R8
    err_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> !res_valid);

    // R9
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_valid && start_ready) |=> !adc_cs_n);

    // R9
    no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_cs_n && !(start_valid && start_ready)) |=> adc_cs_n || !$fell(adc_cs_n));
endmodule

// File: tb/test_adcseq_ctrl.sv
`timescale 1ns/1ps
module test_adcseq_ctrl;
    localparam int T    = 20;
    localparam int SET  = (75 + T - 1) / T;
    localparam int SAM  = (250 + T - 1) / T;
    localparam int RDC  = (60 + T - 1) / T + 1;
    localparam int STL  = (20 + T - 1) / T;
    localparam int GAP  = (50 + T - 1) / T;
    localparam int TO   = 100;
    localparam int DLY1 = 30;
    localparam int DLY2 = 42;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       conv_mode = 1'b0;
    logic       start_valid = 1'b0;
    logic [1:0] start_chan = 2'd0;
    logic       start_ready;
    logic       adc_cs_n, adc_sh_n, adc_rd_n;
    logic [1:0] adc_sel;
    logic       adc_int_n = 1'b1;
    logic [9:0] adc_bus;
    logic       res_valid;
    logic       res_ready = 1'b0;
    logic [9:0] res_data;
    logic [1:0] res_chan;
    logic       timeout_err;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    adcseq_ctrl i_adcseq_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv_mode   (conv_mode),
        .start_valid (start_valid),
        .start_chan  (start_chan),
        .start_ready (start_ready),
        .adc_cs_n    (adc_cs_n),
        .adc_sh_n    (adc_sh_n),
        .adc_rd_n    (adc_rd_n),
        .adc_sel     (adc_sel),
        .adc_int_n   (adc_int_n),
        .adc_data    (adc_bus),
        .res_valid   (res_valid),
        .res_ready   (res_ready),
        .res_data    (res_data),
        .res_chan    (res_chan),
        .timeout_err (timeout_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // ---------------- converter model ----------------
    logic [9:0] held_val = 10'h000;
    logic [9:0] bus_val  = 10'h2AA;
    logic [9:0] smp_val  = 10'h000;
    logic [1:0] smp_ch   = 2'd0;
    int  conv_left = 0;
    int  rd_cnt = 0;
    int  smp_idx = 0;
    bit  mute_f = 1'b0;
    bit  p_sh = 1'b0, p_rd = 1'b0;
    logic [11:0] exp_q[$];

    // bus released when not read; modelled as pulled low
    assign adc_bus = (!adc_cs_n && !adc_rd_n) ? bus_val : 10'h000;

    function automatic logic [9:0] analog(input logic [1:0] ch, input int idx);
        return 10'((int'(ch) * 211 + idx * 37 + 5) % 1024);
    endfunction

    always @(negedge clk) begin
        bit sh_act, rd_act;
        if (rst_n) begin
            sh_act = !adc_cs_n && !adc_sh_n;
            rd_act = !adc_cs_n && !adc_rd_n;
            if (sh_act && !p_sh) begin
                smp_ch  = adc_sel;
                smp_val = analog(adc_sel, smp_idx);
                smp_idx++;
                if (!mute_f) exp_q.push_back({smp_ch, smp_val});
                if (rd_act) conv_left = DLY2;
            end
            if (!sh_act && p_sh && !rd_act && !p_rd) conv_left = DLY1;
            if (conv_left > 0) begin
                conv_left--;
                if (conv_left == 0 && !mute_f) begin
                    adc_int_n = 1'b0;
                    held_val  = smp_val;
                end
            end
            if (!rd_act && p_rd) adc_int_n = 1'b1;
            rd_cnt  = rd_act ? rd_cnt + 1 : 0;
            bus_val = (conv_mode || rd_cnt >= 3) ? held_val : 10'h2AA;
            p_sh = sh_act;
            p_rd = rd_act;
        end
    end

    // ---------------- reference model ----------------
    int m_ph, m_cnt;
    logic [1:0] m_chan, m_rchan;
    logic m_mode, m_valid, m_err, s1, s2;
    logic [9:0] m_data;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph <= 0; m_cnt <= 0; m_chan <= 2'd0; m_rchan <= 2'd0;
            m_mode <= 1'b0; m_valid <= 1'b0; m_err <= 1'b0; m_data <= 10'd0;
            s1 <= 1'b1; s2 <= 1'b1;
        end else begin
            s1 <= adc_int_n;
            s2 <= s1;
            m_err <= 1'b0;
            m_cnt <= m_cnt + 1;
            if (m_valid && res_ready) m_valid <= 1'b0;
            case (m_ph)
                0: if (start_valid && !m_valid) begin
                       m_ph <= 1; m_cnt <= 0; m_chan <= start_chan; m_mode <= conv_mode;
                   end
                1: if (m_cnt == SET - 1) begin m_ph <= 2; m_cnt <= 0; end
                2: if (!m_mode) begin
                       if (m_cnt == SAM - 1) begin m_ph <= 3; m_cnt <= 0; end
                   end else if (!s2) begin
                       m_ph <= 5; m_cnt <= 0;
                   end else if (m_cnt == TO - 1) begin
                       m_ph <= 6; m_cnt <= 0; m_err <= 1'b1;
                   end
                3: if (!s2) begin
                       m_ph <= 4; m_cnt <= 0;
                   end else if (m_cnt == TO - 1) begin
                       m_ph <= 6; m_cnt <= 0; m_err <= 1'b1;
                   end
                4: if (m_cnt == RDC - 1) begin
                       m_ph <= 6; m_cnt <= 0; m_valid <= 1'b1; m_data <= adc_bus; m_rchan <= m_chan;
                   end
                5: if (m_cnt == STL - 1) begin
                       m_ph <= 6; m_cnt <= 0; m_valid <= 1'b1; m_data <= adc_bus; m_rchan <= m_chan;
                   end
                default: if (m_cnt == GAP - 1) begin m_ph <= 0; m_cnt <= 0; end
            endcase
        end
    end

    // ---------------- per-cycle compare and event monitors ----------------
    int low_cnt = 0, high_cnt = 1000, shl_cnt = 0;
    bit pv_cs = 1'b1, pv_sh = 1'b1, pv_rd = 1'b1;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R1 cs_n", adc_cs_n, !(m_ph >= 1 && m_ph <= 5));
            chk("R4 sh_n", adc_sh_n, !(m_ph == 2 || (m_mode && m_ph == 5)));
            chk("R5 rd_n", adc_rd_n, !(m_ph == 4 || (m_mode && (m_ph == 2 || m_ph == 5))));
            chk("R2 sel", adc_sel, m_chan);
            chk("R9 start_ready", start_ready, (m_ph == 0) && !m_valid);
            chk("R10 res_valid", res_valid, m_valid);
            if (m_valid) begin
                chk("R10 res_data", res_data, m_data);
                chk("R10 res_chan", res_chan, m_rchan);
            end
            chk("R8 timeout_err", timeout_err, m_err);
            if (!adc_cs_n && pv_cs) chk("R7 turnaround", int'(high_cnt >= GAP), 1);
            if (!adc_sh_n && pv_sh) begin
                chk("R3 setup", low_cnt + 1, SET);
                chk("R6 joint fall", int'(!adc_rd_n && pv_rd), int'(m_mode));
            end
            if (adc_sh_n && !pv_sh && !adc_cs_n) chk("R4 width", shl_cnt, SAM);
            low_cnt  = adc_cs_n ? 0 : (pv_cs ? 0 : low_cnt + 1);
            high_cnt = adc_cs_n ? (pv_cs ? high_cnt + 1 : 1) : 0;
            shl_cnt  = adc_sh_n ? 0 : shl_cnt + 1;
            pv_cs = adc_cs_n; pv_sh = adc_sh_n; pv_rd = adc_rd_n;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<100000 cycles", cyc);
            finish_run();
        end
    end

    task automatic run_conv(input logic mode, input logic [1:0] ch, input bit mute, input int hold);
        logic [11:0] e;
        bit seen;
        @(negedge clk);
        mute_f      = mute;
        conv_mode   = mode;
        start_chan  = ch;
        start_valid = 1'b1;
        for (int i = 0; i < 50 && !start_ready; i++) @(negedge clk);
        @(negedge clk);
        start_valid = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (res_valid || timeout_err) begin seen = 1'b1; break; end
        end
        if (mute) begin
            chk("R8 timeout seen", int'(timeout_err), 1);
            chk("R8 no result", int'(res_valid), 0);
            mute_f = 1'b0;
            return;
        end
        chk("R10 result arrives", int'(seen && res_valid), 1);
        if (hold > 0) begin
            start_chan  = ~ch;
            start_valid = 1'b1;
            repeat (hold) @(negedge clk);
            chk("R9 held off while pending", int'(adc_cs_n), 1);
            chk("R10 still valid", int'(res_valid), 1);
            start_valid = 1'b0;
        end
        if (exp_q.size() == 0) begin
            chk("R2 expected entry present", 0, 1);
        end else begin
            e = exp_q.pop_front();
            chk("R2 res_chan", res_chan, e[11:10]);
            chk(mode ? "R6 res_data" : "R5 res_data", res_data, e[9:0]);
        end
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        chk("R10 cleared", int'(res_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 cs_n in reset", adc_cs_n, 1);
        chk("R11 sh_n in reset", adc_sh_n, 1);
        chk("R11 rd_n in reset", adc_rd_n, 1);
        chk("R11 res_valid in reset", res_valid, 0);
        chk("R11 err in reset", timeout_err, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 start_ready after reset", start_ready, 1);
        for (int c = 0; c < 4; c++) run_conv(1'b0, 2'(c), 1'b0, 0);
        for (int c = 0; c < 4; c++) run_conv(1'b1, 2'(c), 1'b0, 0);
        run_conv(1'b0, 2'd2, 1'b0, 15);
        run_conv(1'b1, 2'd1, 1'b0, 7);
        run_conv(1'b0, 2'd3, 1'b1, 0);
        run_conv(1'b0, 2'd1, 1'b0, 0);
        run_conv(1'b1, 2'd0, 1'b1, 0);
        run_conv(1'b1, 2'd3, 1'b0, 3);
        run_conv(1'b0, 2'd0, 1'b0, 0);
        repeat (10) @(negedge clk);
        chk("R2 all expected consumed", exp_q.size(), 0);
        done = 1'b1;
        finish_run();
    end
endmodule